// File: doc/BRIEF.md
# CAN Controller Sleep/Wake Sequencer

This block governs the low-power state of a CAN protocol controller. Software asks for sleep by writing a request bit. The sequencer grants the request only when the controller and the bus are quiet. Otherwise it stays awake and tells software through a single-cycle wake-up interrupt. While asleep it watches the sampled bus level, and it wakes on the first dominant level it sees. Software can also wake it by clearing the request bit, and that wake raises no interrupt.

After a wake caused by the bus, the local oscillator has to start up. The node must also find the idle gap at the end of a frame before it may take part again. The sequencer therefore keeps the receive-enable gate closed until the oscillator reports ready and an unbroken run of eleven recessive bits has been counted on the bit strobe. It also drives the select line of the sleep-mode comparator. That line holds the setting that software chose while awake, and it stays frozen for the whole time the block is asleep.

Top module: `can_sleep_seq`

## Requirements
- R1: After reset, sleep_active is 0, wake_irq is 0, rx_en is 1, and cmp_mode takes the value of cmp_sel one clock later.
- R2: A 0-to-1 change of sleep_req seen in the awake state, with irq_pending=0, tx_busy=0, rx_busy=0 and bus_rx=1 (recessive), sets sleep_active at the next clock edge and raises no interrupt.
- R3: A 0-to-1 change of sleep_req while irq_pending=1 or bus_rx=0 (dominant) leaves sleep_active at 0 and pulses wake_irq in the following cycle.
- R4: A 0-to-1 change of sleep_req while tx_busy=1 or rx_busy=1 leaves sleep_active at 0 and pulses wake_irq in the following cycle.
- R5: A refused request is not retried while sleep_req stays 1, even after the blocking condition clears. Only a fresh 0-to-1 change of sleep_req can enter sleep.
- R6: Clearing sleep_req while asleep returns the block to the awake state at the next edge with wake_irq kept at 0 and rx_en kept at 1.
- R7: A dominant bus_rx while asleep with sleep_req=1 clears sleep_active, pulses wake_irq and drops rx_en at the next edge. If sleep_req is cleared in the same cycle, the silent CPU wake of R6 wins.
- R8: After a bus wake, rx_en stays 0 until eleven consecutive recessive bits have been sampled on bit_en strobes while osc_ready=1. rx_en returns to 1 at the edge that samples the eleventh such bit.
- R9: During the wait, a dominant bit on a bit_en strobe restarts the count from zero. Strobes taken while osc_ready=0 do not count.
- R10: wake_irq is never high for two consecutive cycles.
- R11: cmp_mode (1 = each receive line compared with mid-supply, 0 = the two receive lines compared with each other) follows cmp_sel with one clock of delay while the block is not asleep, and holds its value while sleep_active is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_req | input | 1 | Software sleep request level |
| cmp_sel | input | 1 | Requested comparator setting for sleep |
| irq_pending | input | 1 | Controller has an interrupt outstanding |
| tx_busy | input | 1 | A frame is being transmitted |
| rx_busy | input | 1 | A frame is being received |
| bus_rx | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| bit_en | input | 1 | One-cycle strobe per bus bit time |
| osc_ready | input | 1 | Oscillator has finished start-up |
| sleep_active | output | 1 | Block is in sleep |
| wake_irq | output | 1 | One-cycle wake-up interrupt pulse |
| cmp_mode | output | 1 | Comparator mode select for the analog front end |
| rx_en | output | 1 | Receive-enable gate for the protocol engine |

## Verification
The bench refuses entry under each blocking condition in turn and then holds the request high. A design that retried on the level instead of the edge would drop into sleep once the blocker cleared. It runs the idle count with the oscillator not ready, and it breaks the run with a dominant bit part way through. A counter that ignored osc_ready, or that did not restart, would open rx_en too early, and the bench samples rx_en at both the tenth and the eleventh recessive bit to catch a count that is off by one. Clearing the request and driving a dominant level in the same cycle checks that the silent CPU wake takes priority. A frozen-while-asleep check on cmp_mode catches a select line that follows software during sleep.

// File: rtl/can_sleep_pkg.sv
package can_sleep_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE    = 2'd0,
    ST_ASLEEP   = 2'd1,
    ST_IDLE_HUNT = 2'd2
  } slp_state_e;

endpackage

// File: rtl/cslp_ctrl_fsm.sv
module cslp_ctrl_fsm
  import can_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       irq_pending,
  input  logic       tx_busy,
  input  logic       rx_busy,
  input  logic       bus_rx,
  input  logic       idle_found,
  output slp_state_e state_o,
  output logic       wake_irq_o
);

  slp_state_e state_q, state_n;
  logic       req_q;
  logic       irq_q, irq_n;
  logic       req_rise;
  logic       blocked;

  assign req_rise = sleep_req & ~req_q;
  assign blocked  = irq_pending | tx_busy | rx_busy | ~bus_rx;

  always_comb begin
    state_n = state_q;
    irq_n   = 1'b0;
    unique case (state_q)
      ST_AWAKE: begin
        if (req_rise) begin
          if (blocked) irq_n   = 1'b1;
          else         state_n = ST_ASLEEP;
        end
      end
      ST_ASLEEP: begin
        if (!sleep_req) begin
          state_n = ST_AWAKE;
        end else if (!bus_rx) begin
          state_n = ST_IDLE_HUNT;
          irq_n   = 1'b1;
        end
      end
      ST_IDLE_HUNT: begin
        if (idle_found) state_n = ST_AWAKE;
      end
      default: state_n = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_AWAKE;
      req_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      req_q   <= sleep_req;
      irq_q   <= irq_n;
    end
  end

  assign state_o    = state_q;
  assign wake_irq_o = irq_q;

  // R3 / R4: a blocked request keeps the block awake and interrupts
  p_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AWAKE && sleep_req && !req_q && blocked)
      |=> (irq_q && state_q == ST_AWAKE));

  // R6: software wake is silent
  p_cpu_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ASLEEP && !sleep_req) |=> (state_q == ST_AWAKE && !irq_q));

  // R7: bus wake interrupts and starts the idle hunt
  p_bus_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ASLEEP && sleep_req && !bus_rx)
      |=> (state_q == ST_IDLE_HUNT && irq_q));

endmodule

// File: rtl/cslp_idle_counter.sv
module cslp_idle_counter #(
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bit_en,
  input  logic osc_ready,
  input  logic bus_rx,
  output logic idle_found
);

  localparam int unsigned CW = (IDLE_BITS > 1) ? $clog2(IDLE_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          strobe;

  assign strobe = run & bit_en & osc_ready;

  always_comb begin
    cnt_n = cnt_q;
    if (!run) begin
      cnt_n = '0;
    end else if (strobe) begin
      if (!bus_rx)            cnt_n = '0;
      else if (cnt_q == LAST) cnt_n = '0;
      else                    cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign idle_found = strobe & bus_rx & (cnt_q == LAST);

  // R8: the count never passes the final idle bit
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R9: a dominant strobe restarts the run
  p_cnt_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !bus_rx) |=> (cnt_q == '0));

  // R9: without a ready oscillator the count does not move
  p_cnt_osc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !osc_ready) |=> $stable(cnt_q));

endmodule

// File: rtl/cslp_cmp_select.sv
module cslp_cmp_select (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic cmp_sel,
  output logic cmp_mode
);

  logic mode_q;
  logic load;

  assign load = ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= 1'b0;
    else if (load) mode_q <= cmp_sel;
  end

  assign cmp_mode = mode_q;

  // R11: the selection is frozen while asleep
  p_cmp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(mode_q));

endmodule

// File: rtl/can_sleep_seq.sv
module can_sleep_seq
  import can_sleep_pkg::*;
#(
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic cmp_sel,
  input  logic irq_pending,
  input  logic tx_busy,
  input  logic rx_busy,
  input  logic bus_rx,
  input  logic bit_en,
  input  logic osc_ready,
  output logic sleep_active,
  output logic wake_irq,
  output logic cmp_mode,
  output logic rx_en
);

  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  slp_state_e state;
  logic       idle_found;
  logic       hunting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  cslp_ctrl_fsm u_fsm (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .sleep_req  (sleep_req),
    .irq_pending(irq_pending),
    .tx_busy    (tx_busy),
    .rx_busy    (rx_busy),
    .bus_rx     (bus_rx),
    .idle_found (idle_found),
    .state_o    (state),
    .wake_irq_o (wake_irq)
  );

  assign hunting      = (state == ST_IDLE_HUNT);
  assign sleep_active = (state == ST_ASLEEP);
  assign rx_en        = ~hunting;

  cslp_idle_counter #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .run       (hunting),
    .bit_en    (bit_en),
    .osc_ready (osc_ready),
    .bus_rx    (bus_rx),
    .idle_found(idle_found)
  );

  cslp_cmp_select u_cmp (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .hold    (sleep_active),
    .cmp_sel (cmp_sel),
    .cmp_mode(cmp_mode)
  );

  // R10: the interrupt is a single-cycle pulse
  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    wake_irq |=> !wake_irq);

  // R8: reception is never gated off while the block sleeps
  p_gate_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    !rx_en |-> !sleep_active);

  // R2: granting sleep never interrupts
  p_enter_quiet_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(sleep_active) |-> !wake_irq);

endmodule

// File: tb/tb_can_sleep_seq.sv
module tb_can_sleep_seq;

  logic clk = 1'b0;
  logic rst_n;
  logic sleep_req, cmp_sel, irq_pending, tx_busy, rx_busy;
  logic bus_rx, bit_en, osc_ready;
  logic sleep_active, wake_irq, cmp_mode, rx_en;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  can_sleep_seq dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cmp_sel(cmp_sel),
    .irq_pending(irq_pending), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .bus_rx(bus_rx), .bit_en(bit_en), .osc_ready(osc_ready),
    .sleep_active(sleep_active), .wake_irq(wake_irq),
    .cmp_mode(cmp_mode), .rx_en(rx_en)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic act, input logic exp, input string what);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic go_sleep();
    sleep_req = 1'b0;
    tick();
    sleep_req = 1'b1;
    tick();
  endtask

  task automatic send_bit(input logic lvl);
    bus_rx = lvl;
    bit_en = 1'b1;
    tick();
    bit_en = 1'b0;
    bus_rx = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    check(sleep_active, 1'b0, "R1 sleep_active after reset");
    check(wake_irq, 1'b0, "R1 wake_irq after reset");
    check(rx_en, 1'b1, "R1 rx_en after reset");
    check(cmp_mode, 1'b0, "R1 cmp_mode after reset");
  endtask

  task automatic t_enter_and_cpu_wake();
    go_sleep();
    check(sleep_active, 1'b1, "R2 sleep granted");
    check(wake_irq, 1'b0, "R2 no irq on entry");
    tick();
    check(sleep_active, 1'b1, "R2 sleep held");
    sleep_req = 1'b0;
    tick();
    check(sleep_active, 1'b0, "R6 cpu wake clears sleep");
    check(wake_irq, 1'b0, "R6 cpu wake silent");
    check(rx_en, 1'b1, "R6 rx stays enabled");
    tick();
    check(wake_irq, 1'b0, "R6 still silent");
  endtask

  task automatic t_refuse_irq_bus();
    irq_pending = 1'b1;
    go_sleep();
    check(sleep_active, 1'b0, "R3 refused on pending irq");
    check(wake_irq, 1'b1, "R3 irq on refusal (pending)");
    tick();
    check(wake_irq, 1'b0, "R10 irq pulse ends");
    irq_pending = 1'b0;
    bus_rx = 1'b0;
    go_sleep();
    check(sleep_active, 1'b0, "R3 refused on dominant bus");
    check(wake_irq, 1'b1, "R3 irq on refusal (bus)");
    bus_rx = 1'b1;
    tick();
    sleep_req = 1'b0;
    tick();
  endtask

  task automatic t_refuse_busy_no_retry();
    tx_busy = 1'b1;
    go_sleep();
    check(sleep_active, 1'b0, "R4 refused on tx busy");
    check(wake_irq, 1'b1, "R4 irq on tx busy");
    tx_busy = 1'b0;
    tick();
    tick();
    tick();
    check(sleep_active, 1'b0, "R5 no retry while request held");
    check(wake_irq, 1'b0, "R5 no further irq");
    rx_busy = 1'b1;
    go_sleep();
    check(sleep_active, 1'b0, "R4 refused on rx busy");
    check(wake_irq, 1'b1, "R4 irq on rx busy");
    rx_busy = 1'b0;
    go_sleep();
    check(sleep_active, 1'b1, "R5 fresh edge enters sleep");
    sleep_req = 1'b0;
    tick();
  endtask

  task automatic t_bus_wake_idle_hunt();
    osc_ready = 1'b0;
    go_sleep();
    check(sleep_active, 1'b1, "R7 asleep before bus wake");
    bus_rx = 1'b0;
    tick();
    check(sleep_active, 1'b0, "R7 bus wake clears sleep");
    check(wake_irq, 1'b1, "R7 bus wake irq");
    check(rx_en, 1'b0, "R7 rx gated after bus wake");
    bus_rx = 1'b1;
    tick();
    check(wake_irq, 1'b0, "R10 bus wake pulse one cycle");
    for (int i = 0; i < 12; i++) send_bit(1'b1);
    check(rx_en, 1'b0, "R9 strobes without osc ready ignored");
    osc_ready = 1'b1;
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    check(rx_en, 1'b0, "R9 dominant restarts count (10 after)");
    bus_rx = 1'b1;
    bit_en = 1'b1;
    tick();
    bit_en = 1'b0;
    check(rx_en, 1'b1, "R8 rx enabled on eleventh recessive");
    check(sleep_active, 1'b0, "R8 awake after idle hunt");
    sleep_req = 1'b0;
    tick();
  endtask

  task automatic t_wake_priority();
    go_sleep();
    sleep_req = 1'b0;
    bus_rx = 1'b0;
    tick();
    check(sleep_active, 1'b0, "R7 simultaneous clear wakes");
    check(wake_irq, 1'b0, "R7 cpu wake wins, no irq");
    check(rx_en, 1'b1, "R7 cpu wake wins, rx open");
    bus_rx = 1'b1;
    tick();
  endtask

  task automatic t_cmp_select();
    cmp_sel = 1'b1;
    tick();
    check(cmp_mode, 1'b1, "R11 cmp follows while awake");
    go_sleep();
    check(sleep_active, 1'b1, "R11 asleep for hold test");
    cmp_sel = 1'b0;
    tick();
    tick();
    check(cmp_mode, 1'b1, "R11 cmp held while asleep");
    sleep_req = 1'b0;
    tick();
    check(cmp_mode, 1'b1, "R11 cmp held on wake edge");
    tick();
    check(cmp_mode, 1'b0, "R11 cmp follows after wake");
  endtask

  initial begin
    rst_n = 1'b0;
    sleep_req = 1'b0; cmp_sel = 1'b0; irq_pending = 1'b0;
    tx_busy = 1'b0; rx_busy = 1'b0; bus_rx = 1'b1;
    bit_en = 1'b0; osc_ready = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_enter_and_cpu_wake();
    t_refuse_irq_bus();
    t_refuse_busy_no_retry();
    t_bus_wake_idle_hunt();
    t_wake_priority();
    t_cmp_select();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule